// File: doc/BRIEF.md
# Scan-Line Object Pixel Buffer

This block stores the colour codes of moving objects for one display line. It has 256 locations of 4 bits and an 8-bit position counter. The counter is built from a chain of 4-bit stages and steps once on every pixel clock. On each pixel slot the block reads the location under the counter, passes the old contents to the pixel output register, and writes the value on the colour-logic input into that location. When that input is zero, the slot is cleared once it has been shown, so the buffer is empty when the next line starts.

A load strobe moves the counter to a new start position at any point in the line. An active-high disable input blanks every moving object by forcing the output to the transparent code 0. The disable does not stop the counter or the storage updates.

Top module: `sprite_line_buf`

## Requirements
- R1: While `rst` is high at a clock edge, the position counter becomes 0, `pix_out` becomes 0, and no location is written.
- R2: At a clock edge with `rst` and `pos_load` low, the position counter advances by exactly one.
- R3: The position counter goes from 255 to 0 with no extra cycle.
- R4: At a clock edge with `pos_load` high, the counter takes `pos_value`, even when it would otherwise have advanced. The current slot is still read and written at the old position.
- R5: At every clock edge out of reset with `obj_off` low, `pix_out` takes the contents the location under the counter held before that edge.
- R6: At every clock edge out of reset, the location under the counter is overwritten with `col_in`. A `col_in` of 0 leaves the slot empty: 0 is read back on the next pass.
- R7: At a clock edge with `obj_off` high, `pix_out` becomes 0, the transparent code. The counter and the storage updates carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_load | input | 1 | Load the counter with `pos_value` at this edge |
| pos_value | input | 8 | Start position to load |
| col_in | input | 4 | Colour code written into the current slot |
| obj_off | input | 1 | High blanks all moving objects |
| pix_out | output | 4 | Registered colour code of the current slot |

## Verification
The bench keeps its own arithmetic model of the counter and the storage. It covers the wrap from 255 to 0 both on free running and straight after a load to 200, and it loads the values 0 and 255. A counter that skipped the wrap, or that let increment win over load, would show the wrong pattern values after those points. Full-line sweeps check read-then-replace: a buffer that did not clear would repeat the old line, and a buffer that wrote before reading would echo `col_in` instead of the stored value. Periods of `obj_off` check that the output is blanked and that the slots touched during the blanking are still updated. A mid-run reset checks that the counter returns to 0 while the stored data is kept.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int ADDR_W  = 8;
    localparam int STAGE_W = 4;
    localparam int DATA_W  = 4;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int STAGES  = ADDR_W / STAGE_W;

    typedef logic [ADDR_W-1:0] pos_t;
    typedef logic [DATA_W-1:0] col_t;

    typedef struct packed {
        logic load;
        pos_t value;
    } pos_ctl_t;

    localparam col_t TRANSPARENT = '0;

    function automatic logic [STAGE_W-1:0] stage_next(
        input logic [STAGE_W-1:0] cur,
        input logic               cin,
        input logic               ld,
        input logic [STAGE_W-1:0] ldv
    );
        if (ld)
            return ldv;
        return cur + {{(STAGE_W-1){1'b0}}, cin};
    endfunction
endpackage

// File: rtl/slb_pos_counter.sv
module slb_pos_counter
    import slb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pos_ctl_t ctl,
    output pos_t     pos
);
    logic [STAGES:0] carry;
    assign carry[0] = 1'b1;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [STAGE_W-1:0] nib_q;
        assign carry[k+1] = carry[k] & (&nib_q);
        always_ff @(posedge clk) begin
            if (rst)
                nib_q <= '0;
            else
                nib_q <= stage_next(nib_q, carry[k], ctl.load,
                                    ctl.value[k*STAGE_W +: STAGE_W]);
        end
        assign pos[k*STAGE_W +: STAGE_W] = nib_q;
    end

    // R1
    rst_pos_chk: assert property (@(posedge clk) rst |=> pos == '0);
    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> pos == pos_t'($past(pos) + 1'b1));
    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && pos == pos_t'(DEPTH-1)) |=> pos == '0);
    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> pos == $past(ctl.value));
endmodule

// File: rtl/slb_store.sv
module slb_store
    import slb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pos_t pos,
    input  col_t wr_col,
    output col_t rd_col
);
    col_t mem [DEPTH];

    assign rd_col = mem[pos];

    always_ff @(posedge clk) begin
        if (!rst)
            mem[pos] <= wr_col;
    end

    // R6
    replace_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mem[$past(pos)] == $past(wr_col));
endmodule

// File: rtl/slb_out_stage.sv
module slb_out_stage
    import slb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic blank,
    input  col_t rd_col,
    output col_t pix
);
    col_t pix_q;

    always_ff @(posedge clk) begin
        if (rst || blank)
            pix_q <= TRANSPARENT;
        else
            pix_q <= rd_col;
    end
    assign pix = pix_q;

    // R1
    rst_pix_chk: assert property (@(posedge clk) rst |=> pix == TRANSPARENT);
    // R7
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        blank |=> pix == TRANSPARENT);
    // R5
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        !blank |=> pix == $past(rd_col));
endmodule

// File: rtl/sprite_line_buf.sv
module sprite_line_buf
    import slb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pos_load,
    input  logic [ADDR_W-1:0] pos_value,
    input  logic [DATA_W-1:0] col_in,
    input  logic              obj_off,
    output logic [DATA_W-1:0] pix_out
);
    pos_ctl_t ctl;
    pos_t     pos;
    col_t     rd_col;

    assign ctl.load  = pos_load;
    assign ctl.value = pos_value;

    slb_pos_counter u_ctr (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .pos (pos)
    );

    slb_store u_mem (
        .clk    (clk),
        .rst    (rst),
        .pos    (pos),
        .wr_col (col_in),
        .rd_col (rd_col)
    );

    slb_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .blank  (obj_off),
        .rd_col (rd_col),
        .pix    (pix_out)
    );
endmodule

// File: tb/sprite_line_buf_tb.sv
module sprite_line_buf_tb;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pos_load = 1'b0;
    logic [7:0] pos_value = '0;
    logic [3:0] col_in = '0;
    logic       obj_off = 1'b0;
    logic [3:0] pix_out;

    int vectors = 0;
    int errors  = 0;

    logic [3:0] m_mem [256];
    bit         m_known [256];
    logic [7:0] m_pos;

    always #(CLK_NS/2) clk = ~clk;

    sprite_line_buf u_dut (
        .clk(clk), .rst(rst), .pos_load(pos_load), .pos_value(pos_value),
        .col_in(col_in), .obj_off(obj_off), .pix_out(pix_out)
    );

    function automatic logic [3:0] pat(input int i, input int s);
        return 4'((i * 7 + s) % 15 + 1);
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        vectors++;
        if (pix_out !== exp) begin
            errors++;
            $display("FAIL %s: pix_out=%0h expected=%0h at t=%0t", tag, pix_out, exp, $time);
        end
    endtask

    // R1: reset cycle, counter to 0, output 0, storage untouched
    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        m_pos = 8'd0;
        #(CLK_NS/4);
        check("R1", 4'h0);
        rst = 1'b0;
    endtask

    task automatic cyc(input logic [3:0] d, input bit ld, input logic [7:0] lv, input bit off);
        logic [3:0] exp;
        bit         known;
        string      tag;
        col_in = d; pos_load = ld; pos_value = lv; obj_off = off;
        @(posedge clk);
        known = off || m_known[m_pos];
        exp   = off ? 4'h0 : m_mem[m_pos];
        tag   = off ? "R7" : (m_known[m_pos] && d != m_mem[m_pos]) ? "R6/R5" : "R5";
        m_mem[m_pos] = d;               // R6 replace after read
        m_known[m_pos] = 1'b1;
        m_pos = ld ? lv : m_pos + 8'd1; // R4 priority, R2 step, R3 wrap
        #(CLK_NS/4);
        if (known) check(tag, exp);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: expected=finish actual=timeout");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_known[i] = 1'b0;
        m_pos = 8'd0;
        #(CLK_NS/4);
        do_reset();
        // fill one line, then read back with clears (R2, R3, R5, R6)
        for (int i = 0; i < 256; i++) cyc(pat(i, 3), 1'b0, 8'd0, 1'b0);
        for (int i = 0; i < 256; i++) cyc(4'h0, 1'b0, 8'd0, 1'b0);
        // R6: emptied line reads transparent
        for (int i = 0; i < 256; i++) cyc(4'h0, 1'b0, 8'd0, 1'b0);
        // R4: load to 200, run across the R3 wrap
        for (int i = 0; i < 256; i++) cyc(pat(i, 5), 1'b0, 8'd0, 1'b0);
        cyc(4'h0, 1'b1, 8'd200, 1'b0);
        for (int i = 0; i < 70; i++) cyc(4'h0, 1'b0, 8'd0, 1'b0);
        // R4: loads to the ends of the range, load beats step
        cyc(4'h9, 1'b1, 8'd255, 1'b0);
        cyc(4'h3, 1'b0, 8'd0, 1'b0);
        cyc(4'h4, 1'b1, 8'd0, 1'b0);
        cyc(4'h0, 1'b1, 8'd255, 1'b0);
        for (int i = 0; i < 4; i++) cyc(4'h0, 1'b0, 8'd0, 1'b0);
        // R7: blanking while storage keeps updating, with a load inside
        for (int i = 0; i < 256; i++) cyc(pat(i, 11), 1'b0, 8'd0, 1'b0);
        for (int i = 0; i < 100; i++) cyc(pat(i, 2), i == 40, 8'd17, 1'b1);
        for (int i = 0; i < 300; i++) cyc(4'h0, 1'b0, 8'd0, 1'b0);
        // mixed pattern with loads every 37 cycles
        for (int i = 0; i < 1500; i++)
            cyc(4'((i * 13) % 16), (i % 37) == 0, 8'((i * 29) % 256), (i % 53) < 5);
        // R1: mid-run reset keeps the stored data
        do_reset();
        for (int i = 0; i < 512; i++) cyc(4'h0, 1'b0, 8'd0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule